// File: doc/BRIEF.md
# Frame-Sync Synchronous Serial Master

This block is the master end of a four-wire synchronous serial link. Each frame is announced by a frame-sync pulse one serial clock wide, placed just before the most significant bit. Parallel words go into a small transmit FIFO through a valid/ready push port. The block generates the serial clock and shifts each word out MSB first. At the same time it shifts in the word returned by the slave and places it, right-justified, in a receive FIFO. Software or a DMA engine reads that FIFO through a valid/ready pop port.

The serial clock is the system clock divided by an even setting. Word length can be set from 4 to 16 bits and is taken per frame. While the transmit FIFO stays non-empty, frames follow each other with no idle gap. Two DMA request outputs follow the FIFO levels, and each has its own enable bit. While the link is idle, the clock and frame sync are low and the data driver is switched off.

Top module: `ssf_master`

## Requirements
- R1: After reset and between separate frames, `ser_clk` and `ser_fs` are low and `ser_dout_en` is low (data pad in high impedance).
- R2: When the transmit FIFO holds an entry and the link is idle, a frame starts. `ser_fs` goes high on a rising edge of `ser_clk` and stays high for exactly one serial-clock period (`clk_div` system cycles).
- R3: The MSB is launched on the first `ser_clk` rising edge after the frame-sync period. The remaining bits follow MSB first, one per serial-clock period, each changing only at a rising edge. `ser_dout_en` is high for every data bit.
- R4: The number of bits per frame is `frame_bits`, for values 4 to 16. The value is captured when the word leaves the transmit FIFO.
- R5: The serial-clock period is `clk_div` system cycles (even, at least 2). It is high for the first half and low for the second half of each period.
- R6: `ser_din` is sampled at each falling edge of `ser_clk` during a data bit, MSB first. After the LSB, the word is pushed into the receive FIFO right-justified, with zeros above bit `frame_bits`-1.
- R7: If the transmit FIFO is non-empty when the LSB period begins, `ser_fs` is high during that LSB period. The next word's MSB then follows on the very next rising edge, with no idle gap.
- R8: `dma_tx_req` is high exactly when `dma_en[1]` is set and the transmit FIFO holds at most half its depth.
- R9: `dma_rx_req` is high exactly when `dma_en[0]` is set and the receive FIFO holds at least half its depth.
- R10: `tx_ready` is high while the transmit FIFO has space. `rx_valid` is high while the receive FIFO holds data, and `rx_data` shows the oldest word, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word, right-justified |
| tx_ready | output | 1 | Transmit FIFO can accept |
| rx_valid | output | 1 | Receive FIFO holds a word |
| rx_data | output | 16 | Oldest received word |
| rx_ready | input | 1 | Consume the received word |
| clk_div | input | DIV_W | System cycles per serial-clock period (even, >= 2) |
| frame_bits | input | 5 | Bits per frame, 4 to 16 |
| dma_en | input | 2 | Bit 1 enables transmit request, bit 0 enables receive request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| ser_clk | output | 1 | Serial clock |
| ser_fs | output | 1 | Frame-sync pulse |
| ser_dout | output | 1 | Serial data out |
| ser_dout_en | output | 1 | Output enable for the data pad; low means high impedance |
| ser_din | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: an 8-deep FIFO on each side, which puts the half-depth DMA thresholds at 4 entries, and an 8-bit divider. At runtime it sweeps the divider through 2, 4, 6, 8 and 20. The divider of 2 gives the shortest half-period. The divider of 20 slows the link enough that the transmit FIFO fills past its threshold. Frame lengths of 4, 8, 12 and 16 bits cover both ends of the legal range. A three-word burst exercises the overlap of the frame sync with the LSB.

// File: rtl/ssf_pkg.sv
// Shared constants, types and helpers for the frame-sync serial master.
// Assumes frame lengths are at most SSF_MAX_BITS bits.
package ssf_pkg;
    localparam int SSF_MAX_BITS = 16;
    localparam int SSF_MIN_BITS = 4;
    localparam int SSF_FB_W     = 5;

    typedef logic [SSF_MAX_BITS-1:0] ssf_word_t;
    typedef logic [SSF_FB_W-1:0]     ssf_len_t;

    // Force a frame-length setting into the legal range.
    function automatic ssf_len_t ssf_len_clamp(input ssf_len_t n);
        if (n < ssf_len_t'(SSF_MIN_BITS))
            return ssf_len_t'(SSF_MIN_BITS);
        else if (n > ssf_len_t'(SSF_MAX_BITS))
            return ssf_len_t'(SSF_MAX_BITS);
        else
            return n;
    endfunction
endpackage

// File: rtl/ssf_fifo.sv
// Synchronous show-ahead FIFO with an occupancy count.
// A push when full and a pop when empty are ignored. pop_data shows the
// oldest entry whenever empty is low.
module ssf_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    output logic                         full,
    input  logic                         pop,
    output logic [W-1:0]                 pop_data,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          wr_ok, rd_ok;

    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign pop_data = mem[rptr];

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wptr] <= push_data;
    end

    // Move pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (wr_ok)
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (rd_ok)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (wr_ok && !rd_ok)
                level <= level + 1'b1;
            else if (rd_ok && !wr_ok)
                level <= level - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) level <= LW'(DEPTH)); // R10
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!push && !pop) |=> $stable(level)); // R10
endmodule

// File: rtl/ssf_clkgen.sv
// Serial-clock generator. While run is high, a phase counter steps through
// one serial period of div system cycles. The clock is high in the first
// half of the period. An odd div is rounded down, and a div below 2 is
// treated as 2. The phase is held at zero while run is low, so the clock
// starts with a rising edge.
module ssf_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             period_end,
    output logic             mid
);
    logic [DIV_W-1:0] div_eff, half, ph;

    // Round the divider to a legal even value.
    always_comb begin
        if (div < DIV_W'(2))
            div_eff = DIV_W'(2);
        else
            div_eff = {div[DIV_W-1:1], 1'b0};
        half = div_eff >> 1;
    end

    assign sclk       = run && (ph < half);
    assign period_end = run && (ph >= div_eff - 1'b1);
    assign mid        = run && (ph == half - 1'b1);

    // Advance the phase within each serial period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            ph <= '0;
        else if (ph >= div_eff - 1'b1)
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end
endmodule

// File: rtl/ssf_engine.sv
// Frame engine. It pops words from the transmit FIFO, emits the sync slot
// and the data slots, and assembles received bits. A slot is one serial
// period. The sync slot either stands alone or overlaps the LSB slot of
// the previous frame. Assumes clk_div and frame_bits do not change in the
// middle of a frame.
module ssf_engine
    import ssf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_empty,
    input  ssf_word_t tx_word,
    output logic      tx_pop,
    input  ssf_len_t  frame_bits,
    input  logic      sclk,
    input  logic      period_end,
    input  logic      mid,
    input  logic      sdi,
    output logic      rx_push,
    output ssf_word_t rx_word,
    output logic      active,
    output logic      fsync,
    output logic      sdo,
    output logic      sdo_oe
);
    localparam ssf_len_t MAXB = ssf_len_t'(SSF_MAX_BITS);

    logic      sync_q, bit_q;
    ssf_len_t  left, stage_n;
    ssf_word_t tx_sh, rx_sh, stage;
    logic      start, chain, rx_sample;

    assign start     = !active && !tx_empty;
    assign chain     = active && period_end && bit_q && !sync_q
                       && (left == ssf_len_t'(1)) && !tx_empty;
    assign tx_pop    = start || chain;
    assign rx_sample = active && bit_q && mid;
    assign rx_push   = rx_sample && (left == '0);
    assign rx_word   = {rx_sh[SSF_MAX_BITS-2:0], sdi};

    assign fsync  = sync_q;
    assign sdo_oe = bit_q;
    assign sdo    = bit_q && tx_sh[SSF_MAX_BITS-1];

    // Sequence the sync slot and the data slots of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sync_q  <= 1'b0;
            bit_q   <= 1'b0;
            left    <= '0;
            tx_sh   <= '0;
            stage   <= '0;
            stage_n <= ssf_len_t'(SSF_MIN_BITS);
        end else if (start) begin
            active  <= 1'b1;
            sync_q  <= 1'b1;
            bit_q   <= 1'b0;
            stage   <= tx_word;
            stage_n <= ssf_len_clamp(frame_bits);
        end else if (active && period_end) begin
            if (sync_q) begin
                tx_sh  <= stage << (MAXB - stage_n);
                left   <= stage_n - 1'b1;
                bit_q  <= 1'b1;
                sync_q <= 1'b0;
            end else if (left == '0) begin
                active <= 1'b0;
                bit_q  <= 1'b0;
            end else begin
                tx_sh <= tx_sh << 1;
                left  <= left - 1'b1;
                if (chain) begin
                    stage   <= tx_word;
                    stage_n <= ssf_len_clamp(frame_bits);
                    sync_q  <= 1'b1;
                end
            end
        end
    end

    // Shift in received bits, clearing at each new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (active && period_end && sync_q)
            rx_sh <= '0;
        else if (rx_sample)
            rx_sh <= rx_word;
    end

    AST_FS_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(fsync) |-> $rose(sclk)); // R2
    AST_MSB_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe) |-> $rose(sclk)); // R3
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sdo_oe && $past(sdo_oe) && !$rose(sclk)) |-> $stable(sdo)); // R3
    AST_RX_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) rx_push |=> $fell(sclk)); // R6
endmodule

// File: rtl/ssf_master.sv
// Top of the frame-sync serial master. It joins the two FIFOs, the clock
// generator and the frame engine, and derives the DMA requests from the
// FIFO levels. The data pad is driven externally from ser_dout and
// ser_dout_en. A received word that arrives while the receive FIFO is
// full is dropped.
module ssf_master
    import ssf_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_valid,
    input  logic [SSF_MAX_BITS-1:0] tx_data,
    output logic                    tx_ready,
    output logic                    rx_valid,
    output logic [SSF_MAX_BITS-1:0] rx_data,
    input  logic                    rx_ready,
    input  logic [DIV_W-1:0]        clk_div,
    input  logic [SSF_FB_W-1:0]     frame_bits,
    input  logic [1:0]              dma_en,
    output logic                    dma_tx_req,
    output logic                    dma_rx_req,
    output logic                    ser_clk,
    output logic                    ser_fs,
    output logic                    ser_dout,
    output logic                    ser_dout_en,
    input  logic                    ser_din
);
    localparam int LW   = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = FIFO_DEPTH / 2;

    logic            tx_full, tx_empty, tx_pop;
    logic            rx_full, rx_empty, rx_push;
    logic [LW-1:0]   tx_level, rx_level;
    ssf_word_t       tx_word, rx_word;
    logic            active, period_end, mid;

    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;

    ssf_fifo #(.W(SSF_MAX_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_valid), .push_data(tx_data), .full(tx_full),
        .pop(tx_pop), .pop_data(tx_word), .empty(tx_empty), .level(tx_level)
    );

    ssf_fifo #(.W(SSF_MAX_BITS), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word), .full(rx_full),
        .pop(rx_ready), .pop_data(rx_data), .empty(rx_empty), .level(rx_level)
    );

    ssf_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(active), .div(clk_div),
        .sclk(ser_clk), .period_end(period_end), .mid(mid)
    );

    ssf_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .tx_empty(tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .frame_bits(frame_bits),
        .sclk(ser_clk), .period_end(period_end), .mid(mid), .sdi(ser_din),
        .rx_push(rx_push), .rx_word(rx_word),
        .active(active), .fsync(ser_fs), .sdo(ser_dout), .sdo_oe(ser_dout_en)
    );

    // Raise the DMA requests from the FIFO levels under their enables.
    always_comb begin
        dma_tx_req = dma_en[1] && (tx_level <= LW'(HALF));
        dma_rx_req = dma_en[0] && (rx_level >= LW'(HALF));
    end

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (!ser_clk && !$past(ser_clk) && !ser_fs && tx_empty && !ser_dout_en) |=> !ser_dout_en || $rose(ser_clk)); // R1
endmodule

// File: tb/tb_ssf_master.sv
`timescale 1ns/1ps
module tb_ssf_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_ready = 1'b0;
    logic [7:0]  clk_div = 8'd4;
    logic [4:0]  frame_bits = 5'd8;
    logic [1:0]  dma_en = 2'b00;
    logic        dma_tx_req, dma_rx_req;
    logic        ser_clk, ser_fs, ser_dout, ser_dout_en;
    logic        ser_din = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int cur_div = 4;
    int cur_n = 8;

    // Monitor state
    logic [15:0] mon_q[$];
    logic [15:0] got = '0;
    logic [15:0] slv_word = '0;
    int  bits_left = 0;
    int  slv_k = 0;
    int  rise_idx = 0;
    int  last_lsb_idx = -10;
    int  b2b_cnt = 0;
    int  cyc_rise = 0;
    int  hi_cnt = 0;
    int  fs_cnt = 0;
    logic prev_sclk = 1'b0;

    always #2.5 clk = ~clk;

    ssf_master dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .clk_div(clk_div), .frame_bits(frame_bits), .dma_en(dma_en),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
        .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_dout(ser_dout),
        .ser_dout_en(ser_dout_en), .ser_din(ser_din)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] slave_word(input int k);
        return 16'hC3A5 ^ 16'(k * 16'h2F1B);
    endfunction

    function automatic logic [15:0] mask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'h1 << n) - 1);
    endfunction

    // Serial-side monitor and slave model
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sclk = 1'b0; bits_left = 0; hi_cnt = 0; fs_cnt = 0; cyc_rise = 0;
        end else begin
            cyc_rise++;
            if (ser_clk) hi_cnt++;
            else if (prev_sclk) begin
                check(hi_cnt == cur_div / 2, "R5 high time", hi_cnt, cur_div / 2);
                hi_cnt = 0;
            end
            if (ser_fs) fs_cnt++;
            else if (fs_cnt > 0) begin
                check(fs_cnt == cur_div, "R2 sync width", fs_cnt, cur_div);
                fs_cnt = 0;
            end
            if (ser_clk && !prev_sclk) begin
                rise_idx++;
                if (bits_left > 0) begin
                    check(cyc_rise == cur_div, "R5 period", cyc_rise, cur_div);
                    check(ser_dout_en == 1'b1, "R3 output enable", ser_dout_en, 1);
                    if (bits_left == cur_n && rise_idx == last_lsb_idx + 1) b2b_cnt++;
                    ser_din = slv_word[bits_left - 1];
                    got = {got[14:0], ser_dout};
                    bits_left--;
                    if (bits_left == 0) begin
                        mon_q.push_back(got);
                        last_lsb_idx = rise_idx;
                    end
                end
                if (ser_fs) begin
                    bits_left = cur_n;
                    got = '0;
                    slv_word = slave_word(slv_k);
                    slv_k++;
                end
                cyc_rise = 0;
            end
            prev_sclk = ser_clk;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic push_tx(input logic [15:0] w);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = w;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pop_rx(input logic [15:0] exp, input string req);
        @(negedge clk);
        check(rx_valid == 1'b1, "R10 rx_valid", rx_valid, 1);
        check(rx_data == exp, req, rx_data, exp);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic wait_words(input int n);
        while (mon_q.size() < n) @(negedge clk);
        repeat (3 * cur_div + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ser_clk == 0 && ser_fs == 0, "R1 reset clk/fs", {ser_clk, ser_fs}, 0);
        check(ser_dout_en == 0, "R1 reset oe", ser_dout_en, 0);
        check(tx_ready == 1, "R10 reset tx_ready", tx_ready, 1);
        check(rx_valid == 0, "R10 reset rx_valid", rx_valid, 0);
        check(dma_tx_req == 0 && dma_rx_req == 0, "R8 disabled reqs", {dma_tx_req, dma_rx_req}, 0);
    endtask

    task automatic t_single(input int div, input int n, input logic [15:0] w);
        int k0;
        cur_div = div; cur_n = n;
        clk_div = 8'(div); frame_bits = 5'(n);
        k0 = slv_k;
        push_tx(w);
        wait_words(1);
        check(mon_q[0] == (w & mask(n)), "R3 R4 tx word", mon_q[0], w & mask(n));
        void'(mon_q.pop_front());
        check(ser_clk == 0 && ser_fs == 0 && ser_dout_en == 0, "R1 idle after frame",
              {ser_clk, ser_fs, ser_dout_en}, 0);
        pop_rx(slave_word(k0) & mask(n), "R6 rx word");
        @(negedge clk);
        check(rx_valid == 0, "R10 rx empty", rx_valid, 0);
    endtask

    task automatic t_burst();
        int k0, b0;
        cur_div = 4; cur_n = 8;
        clk_div = 8'd4; frame_bits = 5'd8;
        k0 = slv_k; b0 = b2b_cnt;
        push_tx(16'h0081); push_tx(16'h00F0); push_tx(16'h003C);
        wait_words(3);
        check(b2b_cnt - b0 == 2, "R7 back-to-back count", b2b_cnt - b0, 2);
        check(mon_q[0] == 16'h81, "R7 word0", mon_q[0], 16'h81);
        check(mon_q[1] == 16'hF0, "R7 word1", mon_q[1], 16'hF0);
        check(mon_q[2] == 16'h3C, "R7 word2", mon_q[2], 16'h3C);
        mon_q.delete();
        for (int i = 0; i < 3; i++) pop_rx(slave_word(k0 + i) & mask(8), "R6 R10 burst rx order");
    endtask

    task automatic t_dma();
        int k0;
        logic [15:0] ws [6];
        cur_div = 20; cur_n = 4;
        clk_div = 8'd20; frame_bits = 5'd4;
        k0 = slv_k;
        @(negedge clk);
        dma_en = 2'b10;
        @(negedge clk);
        check(dma_tx_req == 1, "R8 tx req empty", dma_tx_req, 1);
        check(dma_rx_req == 0, "R9 rx req masked", dma_rx_req, 0);
        dma_en = 2'b00;
        @(negedge clk);
        check(dma_tx_req == 0, "R8 tx req disabled", dma_tx_req, 0);
        dma_en = 2'b10;
        for (int i = 0; i < 6; i++) begin
            ws[i] = 16'(i * 3 + 5);
            push_tx(ws[i]);
        end
        check(dma_tx_req == 0, "R8 tx above half", dma_tx_req, 0);
        wait_words(6);
        for (int i = 0; i < 6; i++)
            check(mon_q[i] == (ws[i] & mask(4)), "R4 4-bit word", mon_q[i], ws[i] & mask(4));
        mon_q.delete();
        check(dma_tx_req == 1, "R8 tx req drained", dma_tx_req, 1);
        check(dma_rx_req == 0, "R9 rx req disabled", dma_rx_req, 0);
        dma_en = 2'b01;
        @(negedge clk);
        check(dma_rx_req == 1, "R9 rx level 6", dma_rx_req, 1);
        check(dma_tx_req == 0, "R8 tx req masked", dma_tx_req, 0);
        pop_rx(slave_word(k0) & mask(4), "R6 dma rx0");
        pop_rx(slave_word(k0 + 1) & mask(4), "R6 dma rx1");
        check(dma_rx_req == 1, "R9 rx level 4", dma_rx_req, 1);
        pop_rx(slave_word(k0 + 2) & mask(4), "R6 dma rx2");
        check(dma_rx_req == 0, "R9 rx level 3", dma_rx_req, 0);
        for (int i = 3; i < 6; i++) pop_rx(slave_word(k0 + i) & mask(4), "R6 dma rx tail");
        dma_en = 2'b00;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single(4, 8, 16'h00A5);
        t_single(2, 4, 16'h0009);
        t_single(6, 16, 16'hBEEF);
        t_single(8, 12, 16'hF5A3);
        t_burst();
        t_dma();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule